// File: doc/BRIEF.md
# Real-Time Clock Counter Write Interlock

This block guards the time and calendar counters of a real-time clock while a serial host rewrites them. It watches the host's chip-enable line, a one-hertz carry pulse from the prescaler and an oscillator-good indication. It drives three flags back to the host: busy, write-enable and oscillation-stop. It also drives an increment strobe into the counter chain. In free-running mode, every seconds carry becomes an increment strobe, and the busy flag covers the cycles in which that carry ripples through the counters.

When the host raises chip-enable, the block waits for a cycle with no busy and no carry. It then clears write-enable, and from that point the host may write the counters. Carries that arrive while the counters are held are folded into one saturating pending bit. When the host drops chip-enable, write-enable returns to 1 and at most one increment is applied. The clock therefore loses a second if two carries were missed during the hold.

The block also keeps two further pieces of state. The first is an oscillation-stop latch, which is set while the oscillator is down and is cleared by a control-register-1 write, but only while the oscillator runs. The second is the 12/24-hour mode bit, which is loaded from a control-register-2 write.

Top module: `rtc_write_guard`

## Requirements
- R1: While reset is active, busyFlag=1, writeEnFlag=1, oscStopFlag=1, hour24=0 and incStrobe=0.
- R2: busyFlag stays 1 until oscGood has been high on STARTUP_CYCLES consecutive clock edges, and it reads 0 after exactly that many edges. A low oscGood sets busyFlag to 1 on the next cycle and restarts the count.
- R3: A low oscGood sets oscStopFlag to 1 on the next cycle. A ctrl1Wr pulse clears oscStopFlag only if oscGood is high on that edge; otherwise the flag stays 1.
- R4: While writeEnFlag=1 and the oscillator has settled, a secCarry on one edge gives incStrobe=1 for exactly the following cycle. busyFlag reads 1 for PROP_CYCLES cycles, starting with that strobe cycle. secCarry before the oscillator has settled produces no strobe.
- R5: writeEnFlag falls to 0 only on an edge at which chipEn=1, busyFlag=0 and no secCarry is present. A carry on that edge is propagated instead, and the grant follows once busy clears.
- R6: An edge at which chipEn=0 and writeEnFlag=0 sets writeEnFlag back to 1 on the next cycle.
- R7: While writeEnFlag=0 and chipEn=1, no incStrobe is produced. On release, exactly one incStrobe follows if at least one carry arrived during the hold or on the release edge itself. Otherwise no strobe follows.
- R8: Two or three carries during one hold still yield exactly one incStrobe on release, because the pending indicator is a single saturating bit.
- R9: A ctrl2Wr pulse loads hour24 from ctrl2Data bit 2: 4h selects 24-hour mode (hour24=1) and 0h selects 12-hour mode (hour24=0). Without ctrl2Wr, hour24 holds its value.
- R10: An increment issued on release sets busyFlag to 1 in the strobe cycle, in the same way as a free-running carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| chipEn | input | 1 | Host chip-enable; high requests the counters, low releases them |
| secCarry | input | 1 | One-cycle seconds carry pulse from the prescaler |
| oscGood | input | 1 | High while the oscillator is running |
| ctrl1Wr | input | 1 | One-cycle strobe: host writes control register 1 |
| ctrl2Wr | input | 1 | One-cycle strobe: host writes control register 2 |
| ctrl2Data | input | 4 | Data of the control register 2 write; bit 2 is the 12/24 select |
| busyFlag | output | 1 | Oscillator settling or carry propagation in progress |
| writeEnFlag | output | 1 | 1 = counters free-running; 0 = host holds them for writing |
| oscStopFlag | output | 1 | Oscillation-stop latch |
| hour24 | output | 1 | 1 = 24-hour display, 0 = 12-hour display |
| incStrobe | output | 1 | One-second increment strobe to the counter chain |

## Verification
Two functions can fall into the same clock edge: a seconds carry and a change of chipEn. In one case the carry lands on the edge where the host releases the counters. In the other it lands on the edge where a grant would otherwise happen. The bench provokes the release case by sweeping 0 to 3 carries during a hold, each combined with and without a carry on the release edge. It judges each combination by counting incStrobe pulses across the release window and comparing the count with one if any carry occurred and zero otherwise. The grant collision is provoked from an idle, settled state. The bench expects write-enable to stay 1 while a strobe goes out, and it expects the grant to arrive only after busy has been seen at 0.

// File: rtl/rtc_guard_pkg.sv
package rtc_guard_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic fireInc;     // launch one increment into the counter chain
    logic setPending;  // remember a carry that arrived during a hold
    logic clrPending;  // hold released: pending carry consumed
    logic clrOscStop;  // qualified control register 1 write
    logic wrMode;      // control register 2 write
  } ctrlStrobes_t;

  // State reported back from the datapath
  typedef struct packed {
    logic settled;     // oscillator start-up count complete
    logic propBusy;    // carry propagation window open
    logic pending;     // deferred increment waiting for release
  } dpStatus_t;

endpackage

// File: rtl/rtc_guard_datapath.sv
module rtc_guard_datapath
  import rtc_guard_pkg::*;
#(
  parameter int STARTUP_CYCLES = 1024,
  parameter int PROP_CYCLES    = 4,
  parameter int MODE_BIT       = 2,
  parameter int CTRL_W         = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscGood,
  input  logic [CTRL_W-1:0] ctrl2Data,
  input  ctrlStrobes_t      strobes,
  output dpStatus_t         status,
  output logic              oscStopQ,
  output logic              hour24Q,
  output logic              incStrobeQ
);

  localparam int SW = (STARTUP_CYCLES < 1) ? 1 : $clog2(STARTUP_CYCLES + 1);
  localparam int PW = $clog2(PROP_CYCLES + 1);
  localparam logic [PW-1:0] PROP_LOAD = PW'(PROP_CYCLES);

  logic          settledQ;
  logic [PW-1:0] propCnt;
  logic          pendingQ;

  // Oscillator settling: a variant picked by the start-up count
  generate
    if (STARTUP_CYCLES == 0) begin : gNoSettle
      assign settledQ = oscGood;
    end else begin : gSettle
      localparam logic [SW-1:0] SETTLE_END = SW'(STARTUP_CYCLES);
      logic [SW-1:0] settleCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          settleCnt <= '0;
        end else if (!oscGood) begin
          settleCnt <= '0;
        end else if (settleCnt != SETTLE_END) begin
          settleCnt <= settleCnt + 1'b1;
        end
      end
      assign settledQ = (settleCnt == SETTLE_END);

      // R2
      settle_needs_osc_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(settledQ) |-> $past(oscGood));
    end
  endgenerate

  // Carry propagation window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      propCnt <= '0;
    end else if (strobes.fireInc) begin
      propCnt <= PROP_LOAD;
    end else if (propCnt != '0) begin
      propCnt <= propCnt - 1'b1;
    end
  end

  // R4
  prop_window_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    propCnt <= PROP_LOAD);

  // Saturating deferred-increment bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
    end else if (strobes.clrPending) begin
      pendingQ <= 1'b0;
    end else if (strobes.setPending) begin
      pendingQ <= 1'b1;
    end
  end

  // R8
  pending_saturates_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && !strobes.clrPending) |=> pendingQ);

  // Oscillation-stop latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscStopQ <= 1'b1;
    end else if (!oscGood) begin
      oscStopQ <= 1'b1;
    end else if (strobes.clrOscStop) begin
      oscStopQ <= 1'b0;
    end
  end

  // R3
  osc_stop_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oscGood |=> oscStopQ);

  // 12/24-hour select and increment strobe register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hour24Q    <= 1'b0;
      incStrobeQ <= 1'b0;
    end else begin
      incStrobeQ <= strobes.fireInc;
      if (strobes.wrMode) begin
        hour24Q <= ctrl2Data[MODE_BIT];
      end
    end
  end

  // R9
  mode_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrMode |=> $stable(hour24Q));

  assign status.settled  = settledQ;
  assign status.propBusy = (propCnt != '0);
  assign status.pending  = pendingQ;

endmodule

// File: rtl/rtc_guard_control.sv
module rtc_guard_control
  import rtc_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         chipEn,
  input  logic         secCarry,
  input  logic         oscGood,
  input  logic         ctrl1Wr,
  input  logic         ctrl2Wr,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes,
  output logic         busyFlag,
  output logic         writeEnQ
);

  logic carryEvt;
  logic holdNow;
  logic releaseNow;
  logic grantNow;

  assign busyFlag   = !status.settled || status.propBusy;
  assign carryEvt   = secCarry && status.settled;
  assign holdNow    = !writeEnQ;
  assign releaseNow = holdNow && !chipEn;
  // Access only in a carry-free, non-busy cycle
  assign grantNow   = writeEnQ && chipEn && !busyFlag && !carryEvt;

  always_comb begin
    strobes            = '0;
    strobes.clrOscStop = ctrl1Wr && oscGood;
    strobes.wrMode     = ctrl2Wr;
    if (writeEnQ) begin
      strobes.fireInc = carryEvt;
    end else if (releaseNow) begin
      strobes.fireInc    = status.pending || carryEvt;
      strobes.clrPending = 1'b1;
    end else begin
      strobes.setPending = carryEvt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeEnQ <= 1'b1;
    end else if (releaseNow) begin
      writeEnQ <= 1'b1;
    end else if (grantNow) begin
      writeEnQ <= 1'b0;
    end
  end

  // R5
  grant_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(writeEnQ) |-> ($past(chipEn) && !$past(busyFlag) && !$past(secCarry)));

  // R6
  release_restores_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chipEn && !writeEnQ) |=> writeEnQ);

  // R2
  osc_loss_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oscGood |=> busyFlag);

endmodule

// File: rtl/rtc_write_guard.sv
module rtc_write_guard
  import rtc_guard_pkg::*;
#(
  parameter int STARTUP_CYCLES = 1024,
  parameter int PROP_CYCLES    = 4,
  parameter int MODE_BIT       = 2,
  parameter int CTRL_W         = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEn,
  input  logic              secCarry,
  input  logic              oscGood,
  input  logic              ctrl1Wr,
  input  logic              ctrl2Wr,
  input  logic [CTRL_W-1:0] ctrl2Data,
  output logic              busyFlag,
  output logic              writeEnFlag,
  output logic              oscStopFlag,
  output logic              hour24,
  output logic              incStrobe
);

  ctrlStrobes_t strobes;
  dpStatus_t    status;

  rtc_guard_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .chipEn   (chipEn),
    .secCarry (secCarry),
    .oscGood  (oscGood),
    .ctrl1Wr  (ctrl1Wr),
    .ctrl2Wr  (ctrl2Wr),
    .status   (status),
    .strobes  (strobes),
    .busyFlag (busyFlag),
    .writeEnQ (writeEnFlag)
  );

  rtc_guard_datapath #(
    .STARTUP_CYCLES (STARTUP_CYCLES),
    .PROP_CYCLES    (PROP_CYCLES),
    .MODE_BIT       (MODE_BIT),
    .CTRL_W         (CTRL_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .oscGood    (oscGood),
    .ctrl2Data  (ctrl2Data),
    .strobes    (strobes),
    .status     (status),
    .oscStopQ   (oscStopFlag),
    .hour24Q    (hour24),
    .incStrobeQ (incStrobe)
  );

  // R7
  no_inc_while_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chipEn && !writeEnFlag) |=> !incStrobe);

  // R10
  inc_marks_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    incStrobe |-> busyFlag);

endmodule

// File: tb/rtc_write_guard_test.sv
module rtc_write_guard_test;

  localparam int CLK_PERIOD = 10;
  localparam int STARTUP    = 8;
  localparam int PROP       = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chipEn = 1'b0;
  logic       secCarry = 1'b0;
  logic       oscGood = 1'b0;
  logic       ctrl1Wr = 1'b0;
  logic       ctrl2Wr = 1'b0;
  logic [3:0] ctrl2Data = 4'h0;
  logic       busyFlag, writeEnFlag, oscStopFlag, hour24, incStrobe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_write_guard #(
    .STARTUP_CYCLES (STARTUP),
    .PROP_CYCLES    (PROP)
  ) uut (
    .clk         (clk),
    .rstN        (rstN),
    .chipEn      (chipEn),
    .secCarry    (secCarry),
    .oscGood     (oscGood),
    .ctrl1Wr     (ctrl1Wr),
    .ctrl2Wr     (ctrl2Wr),
    .ctrl2Data   (ctrl2Data),
    .busyFlag    (busyFlag),
    .writeEnFlag (writeEnFlag),
    .oscStopFlag (oscStopFlag),
    .hour24      (hour24),
    .incStrobe   (incStrobe)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Raise chipEn and wait for the grant; the grant edge must have seen busy=0
  task automatic acquire(input string tag);
    int waited = 0;
    logic busyBefore = 1'b1;
    chipEn = 1'b1;
    while (writeEnFlag && waited < 20) begin
      busyBefore = busyFlag;
      tick();
      waited++;
    end
    chk({tag, " R5 grant reached"}, int'(writeEnFlag), 0);
    chk({tag, " R5 busy clear on grant edge"}, int'(busyBefore), 0);
    chk({tag, " R5 grant latency bound"}, int'(waited <= PROP + 2), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int incCount;
    // R1 reset state
    tick();
    chk("R1 busy", int'(busyFlag), 1);
    chk("R1 writeEn", int'(writeEnFlag), 1);
    chk("R1 oscStop", int'(oscStopFlag), 1);
    chk("R1 hour24", int'(hour24), 0);
    chk("R1 incStrobe", int'(incStrobe), 0);

    // R2/R3 oscillator down after reset
    rstN = 1'b1;
    repeat (3) tick();
    chk("R2 busy while osc down", int'(busyFlag), 1);
    ctrl1Wr = 1'b1;
    tick();
    ctrl1Wr = 1'b0;
    chk("R3 ctrl1 write with osc down ignored", int'(oscStopFlag), 1);

    // R2 settling count, R4 carry before settling ignored
    oscGood = 1'b1;
    incCount = 0;
    for (int i = 1; i < STARTUP; i++) begin
      secCarry = (i == 3);
      tick();
      incCount += int'(incStrobe);
      chk("R2 busy during settling", int'(busyFlag), 1);
    end
    secCarry = 1'b0;
    tick();
    chk("R2 busy clears after settling count", int'(busyFlag), 0);
    chk("R4 early carry dropped", incCount, 0);

    // R3 clear while running
    ctrl1Wr = 1'b1;
    tick();
    ctrl1Wr = 1'b0;
    chk("R3 cleared with osc running", int'(oscStopFlag), 0);

    // R4 free-running carry and busy window
    secCarry = 1'b1;
    tick();
    secCarry = 1'b0;
    chk("R4 strobe after carry", int'(incStrobe), 1);
    chk("R4 busy in strobe cycle", int'(busyFlag), 1);
    for (int i = 2; i <= PROP; i++) begin
      tick();
      chk("R4 strobe single cycle", int'(incStrobe), 0);
      chk("R4 busy window", int'(busyFlag), 1);
    end
    tick();
    chk("R4 busy ends after window", int'(busyFlag), 0);

    // R5 carry on the grant edge: no grant, carry propagated
    chipEn = 1'b1;
    secCarry = 1'b1;
    tick();
    secCarry = 1'b0;
    chk("R5 no grant on carry edge", int'(writeEnFlag), 1);
    chk("R5 carry propagated on grant edge", int'(incStrobe), 1);
    acquire("collision");
    chipEn = 1'b0;
    tick();
    chk("R6 release restores writeEn", int'(writeEnFlag), 1);
    repeat (PROP + 2) tick();

    // R7/R8/R10 sweep: held carries x carry on release edge
    for (int n = 0; n < 4; n++) begin
      for (int rc = 0; rc < 2; rc++) begin
        int expInc;
        string tag;
        tag = $sformatf("n=%0d rc=%0d", n, rc);
        expInc = (n > 0 || rc == 1) ? 1 : 0;
        acquire(tag);
        for (int k = 0; k < n; k++) begin
          secCarry = 1'b1;
          tick();
          secCarry = 1'b0;
          chk({tag, " R7 no strobe while held"}, int'(incStrobe), 0);
          chk({tag, " R7 still held"}, int'(writeEnFlag), 0);
          tick();
          chk({tag, " R7 no strobe while held"}, int'(incStrobe), 0);
        end
        chipEn = 1'b0;
        secCarry = (rc == 1);
        tick();
        secCarry = 1'b0;
        chk({tag, " R6 writeEn after release"}, int'(writeEnFlag), 1);
        chk({tag, " R10 busy on released increment"}, int'(busyFlag), expInc);
        incCount = int'(incStrobe);
        repeat (PROP + 3) begin
          tick();
          incCount += int'(incStrobe);
        end
        if (n >= 2)
          chk({tag, " R8 saturated single increment"}, incCount, expInc);
        else
          chk({tag, " R7 increments on release"}, incCount, expInc);
      end
    end

    // R2/R3 oscillator halt while settled
    oscGood = 1'b0;
    tick();
    chk("R3 stop latched on halt", int'(oscStopFlag), 1);
    chk("R2 busy on halt", int'(busyFlag), 1);
    ctrl1Wr = 1'b1;
    tick();
    chk("R3 write during halt ignored", int'(oscStopFlag), 1);
    oscGood = 1'b1;
    tick();
    ctrl1Wr = 1'b0;
    chk("R3 cleared after restart", int'(oscStopFlag), 0);
    chk("R2 count restarted", int'(busyFlag), 1);
    repeat (STARTUP) tick();
    chk("R2 settled again", int'(busyFlag), 0);

    // R9 sweep over every control register 2 value
    for (int d = 0; d < 16; d++) begin
      logic [3:0] dv;
      int expMode;
      dv = 4'(d);
      expMode = int'(dv[2]);
      ctrl2Data = dv;
      ctrl2Wr = 1'b1;
      tick();
      ctrl2Wr = 1'b0;
      chk($sformatf("R9 mode after write %0h", d), int'(hour24), expMode);
      ctrl2Data = ~dv;
      tick();
      chk($sformatf("R9 mode held without write %0h", d), int'(hour24), expMode);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule